// File: doc/BRIEF.md
# RF Power and Arc Trip Interlock

This block is the fast protection stage in front of an RF drive path. It watches eight sampled RF power levels, fourteen arc-detector lines, a small set of software interlock requests and one hardware vacuum-good signal. When any armed source reports a fault it raises a trip. The trip cuts the RF drive, stays asserted until an operator clears it, and is repeated on two independently registered output lines so that a single stuck line does not hide it.

Each RF channel carries its own power limit and its own time allowance, counted in clock cycles. A brief excursion above the limit is tolerated. Only an excursion that lasts longer than the allowance, and that falls inside the RF gate window, counts as a fault. Arc, software and RF sources can each be masked. The vacuum-good input cannot be masked. Along with the trip, the block records which source fired first, so the cause can be read after the event.

Top module: `rf_trip_interlock`

## Requirements
- R1: An enabled RF channel whose sample is strictly above its limit in L+1 consecutive gated cycles (L = its time limit) produces a fault in the (L+1)-th such cycle. The trip outputs go high on the next clock edge. After L over-limit cycles followed by a drop, no trip occurs.
- R2: A sample equal to or below the channel limit restarts that channel's over-limit count from zero.
- R3: While rf_gate is low, RF channels cannot cause a trip. A low gate also restarts every channel's count.
- R4: An enabled arc input that is high in a cycle sets the trip on the next clock edge, without time qualification.
- R5: Clearing a bit of ch_enable, arc_enable or sw_enable stops that source from causing a trip.
- R6: When vacuum_ok is low, the trip is set on the next clock edge, whatever the enables and the gate are doing.
- R7: An enabled software request (sw_req bit high) sets the trip on the next clock edge.
- R8: After reset the trip is low. Once set, the trip stays set until trip_clear is high in a cycle where no source is active. A clear that arrives while a source is active has no effect.
- R9: trip_a and trip_b are driven by separate registers and always carry the same value.
- R10: fault_code holds the source of the first fault and keeps it until the trip is cleared. It is 0 when there is no trip. The codes are: vacuum 1, RF channel k is 2+k, arc k is 10+k, software k is 24+k. When several sources fire in the same cycle, the lowest code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_gate | input | 1 | RF gate window; RF channels are judged only while it is high |
| pwr_sample | input | 96 | Eight 12-bit power samples; channel k is at bits [12k+11:12k] |
| pwr_limit | input | 96 | Eight 12-bit power limits, packed the same way |
| time_limit | input | 80 | Eight 10-bit time allowances in cycles; channel k is at bits [10k+9:10k] |
| ch_enable | input | 8 | Per-channel RF enable |
| arc_in | input | 14 | Arc detector lines, active high |
| arc_enable | input | 14 | Per-arc enable |
| sw_req | input | 2 | Software interlock requests, active high |
| sw_enable | input | 2 | Per-request enable |
| vacuum_ok | input | 1 | Vacuum good; low trips and cannot be masked |
| trip_clear | input | 1 | Clear pulse for the latched trip |
| trip_a | output | 1 | Trip, line A |
| trip_b | output | 1 | Trip, line B (redundant copy) |
| fault_code | output | 5 | Code of the first fault source |

## Verification
The assertions check these rules on every cycle: a loss of vacuum, or any armed source, sets the trip on the next edge; the trip holds while no clear arrives; the two trip lines agree; the recorded fault code stays put during a trip; and no RF channel can fault while the gate is closed. The exact cycle on which a channel crosses its time allowance can only be shown by the bench's scenarios. The same goes for the restart of the count after a dip to the limit or a gate drop, the mask bits, the code priority when sources fire together, and the refusal to clear while a source is still active.

// File: rtl/rfil_pkg.sv
package rfil_pkg;

    localparam int unsigned DEF_N_CH  = 8;
    localparam int unsigned DEF_N_ARC = 14;
    localparam int unsigned DEF_N_SW  = 2;
    localparam int unsigned DEF_PWR_W = 12;
    localparam int unsigned DEF_TMR_W = 10;

    // Source vector layout: bit 0 vacuum, then RF, then arc, then software.
    function automatic int unsigned src_count(input int unsigned n_ch,
                                              input int unsigned n_arc,
                                              input int unsigned n_sw);
        return 1 + n_ch + n_arc + n_sw;
    endfunction

    function automatic int unsigned code_width(input int unsigned n_src);
        return $clog2(n_src + 1);
    endfunction

endpackage

// File: rtl/rfil_chan_qual.sv
module rfil_chan_qual #(
    parameter int unsigned PWR_W = rfil_pkg::DEF_PWR_W,
    parameter int unsigned TMR_W = rfil_pkg::DEF_TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate,
    input  logic             enable,
    input  logic [PWR_W-1:0] sample,
    input  logic [PWR_W-1:0] limit,
    input  logic [TMR_W-1:0] tlim,
    output logic             fault
);

    logic             over;
    logic [TMR_W-1:0] run_cnt;

    assign over = gate && (sample > limit);

    always_ff @(posedge clk) begin
        if (rst || !over) begin
            run_cnt <= '0;
        end else if (run_cnt != {TMR_W{1'b1}}) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign fault = over && enable && (run_cnt >= tlim);

    AST_FAULT_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (rst)
        (fault && tlim != '0) |-> $past(over)); // R1

endmodule

// File: rtl/rfil_trip_latch.sv
module rfil_trip_latch #(
    parameter int unsigned N_SRC  = 25,
    parameter int unsigned CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_act,
    input  logic              trip_clear,
    output logic              trip_a,
    output logic              trip_b,
    output logic [CODE_W-1:0] fault_code
);

    logic              any_act;
    logic [CODE_W-1:0] first_code;

    assign any_act = |src_act;

    // Lowest index wins.
    always_comb begin
        first_code = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (src_act[i]) first_code = CODE_W'(i + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_a <= 1'b0;
        end else if (any_act) begin
            trip_a <= 1'b1;
        end else if (trip_clear) begin
            trip_a <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_b <= 1'b0;
        end else if (any_act) begin
            trip_b <= 1'b1;
        end else if (trip_clear) begin
            trip_b <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_code <= '0;
        end else if (any_act && !trip_a) begin
            fault_code <= first_code;
        end else if (!any_act && trip_clear) begin
            fault_code <= '0;
        end
    end

    AST_SET_ON_SOURCE: assert property (@(posedge clk) disable iff (rst)
        any_act |=> trip_a); // R4
    AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (trip_a && !trip_clear) |=> trip_a); // R8
    AST_LINES_AGREE: assert property (@(posedge clk) disable iff (rst)
        trip_a == trip_b); // R9
    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (trip_a && $past(trip_a)) |-> $stable(fault_code)); // R10
    AST_CODE_SET: assert property (@(posedge clk) disable iff (rst)
        trip_a |-> fault_code != '0); // R10

endmodule

// File: rtl/rf_trip_interlock.sv
module rf_trip_interlock #(
    parameter int unsigned N_CH  = rfil_pkg::DEF_N_CH,
    parameter int unsigned N_ARC = rfil_pkg::DEF_N_ARC,
    parameter int unsigned N_SW  = rfil_pkg::DEF_N_SW,
    parameter int unsigned PWR_W = rfil_pkg::DEF_PWR_W,
    parameter int unsigned TMR_W = rfil_pkg::DEF_TMR_W,
    localparam int unsigned N_SRC  = rfil_pkg::src_count(N_CH, N_ARC, N_SW),
    localparam int unsigned CODE_W = rfil_pkg::code_width(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rf_gate,
    input  logic [N_CH*PWR_W-1:0]   pwr_sample,
    input  logic [N_CH*PWR_W-1:0]   pwr_limit,
    input  logic [N_CH*TMR_W-1:0]   time_limit,
    input  logic [N_CH-1:0]         ch_enable,
    input  logic [N_ARC-1:0]        arc_in,
    input  logic [N_ARC-1:0]        arc_enable,
    input  logic [N_SW-1:0]         sw_req,
    input  logic [N_SW-1:0]         sw_enable,
    input  logic                    vacuum_ok,
    input  logic                    trip_clear,
    output logic                    trip_a,
    output logic                    trip_b,
    output logic [CODE_W-1:0]       fault_code
);

    logic [N_CH-1:0]  rf_fault;
    logic [N_SRC-1:0] src_act;

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        rfil_chan_qual #(
            .PWR_W(PWR_W),
            .TMR_W(TMR_W)
        ) u_qual (
            .clk    (clk),
            .rst    (rst),
            .gate   (rf_gate),
            .enable (ch_enable[k]),
            .sample (pwr_sample[k*PWR_W +: PWR_W]),
            .limit  (pwr_limit[k*PWR_W +: PWR_W]),
            .tlim   (time_limit[k*TMR_W +: TMR_W]),
            .fault  (rf_fault[k])
        );
    end

    assign src_act = {sw_req & sw_enable, arc_in & arc_enable, rf_fault, ~vacuum_ok};

    rfil_trip_latch #(
        .N_SRC (N_SRC),
        .CODE_W(CODE_W)
    ) u_latch (
        .clk        (clk),
        .rst        (rst),
        .src_act    (src_act),
        .trip_clear (trip_clear),
        .trip_a     (trip_a),
        .trip_b     (trip_b),
        .fault_code (fault_code)
    );

    AST_VACUUM_TRIP: assert property (@(posedge clk) disable iff (rst)
        !vacuum_ok |=> (trip_a && trip_b)); // R6
    AST_NO_RF_OFF_GATE: assert property (@(posedge clk) disable iff (rst)
        !rf_gate |-> rf_fault == '0); // R3

endmodule

// File: tb/sim_rf_trip_interlock.sv
module sim_rf_trip_interlock;

    localparam int NC = 8;
    localparam int NA = 14;
    localparam int NS = 2;
    localparam int PW = 12;
    localparam int TW = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              rf_gate;
    logic [NC*PW-1:0]  pwr_sample;
    logic [NC*PW-1:0]  pwr_limit;
    logic [NC*TW-1:0]  time_limit;
    logic [NC-1:0]     ch_enable;
    logic [NA-1:0]     arc_in;
    logic [NA-1:0]     arc_enable;
    logic [NS-1:0]     sw_req;
    logic [NS-1:0]     sw_enable;
    logic              vacuum_ok;
    logic              trip_clear;
    logic              trip_a;
    logic              trip_b;
    logic [4:0]        fault_code;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    rf_trip_interlock u0 (
        .clk(clk), .rst(rst), .rf_gate(rf_gate),
        .pwr_sample(pwr_sample), .pwr_limit(pwr_limit), .time_limit(time_limit),
        .ch_enable(ch_enable), .arc_in(arc_in), .arc_enable(arc_enable),
        .sw_req(sw_req), .sw_enable(sw_enable), .vacuum_ok(vacuum_ok),
        .trip_clear(trip_clear), .trip_a(trip_a), .trip_b(trip_b),
        .fault_code(fault_code)
    );

    typedef struct packed {
        logic [2:0]  ch;
        logic [11:0] smp;
        logic [11:0] lim;
        logic [9:0]  tl;
        logic [7:0]  cyc;
        logic        exp_trip;
    } vec_t;

    // Trip expected iff cyc >= tl+1 with sample strictly above limit (R1, R2).
    localparam vec_t VEC [8] = '{
        '{3'd0, 12'd100,  12'd200, 10'd2,  8'd20, 1'b0},
        '{3'd1, 12'd200,  12'd200, 10'd0,  8'd20, 1'b0},
        '{3'd2, 12'd201,  12'd200, 10'd0,  8'd1,  1'b1},
        '{3'd3, 12'd500,  12'd100, 10'd5,  8'd5,  1'b0},
        '{3'd3, 12'd500,  12'd100, 10'd5,  8'd6,  1'b1},
        '{3'd7, 12'd4095, 12'd0,   10'd10, 8'd11, 1'b1},
        '{3'd5, 12'd300,  12'd100, 10'd10, 8'd10, 1'b0},
        '{3'd6, 12'd1,    12'd0,   10'd30, 8'd31, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic set_ch(input int k, input int smp, input int lim, input int tl);
        pwr_sample[k*PW +: PW] = PW'(smp);
        pwr_limit[k*PW +: PW]  = PW'(lim);
        time_limit[k*TW +: TW] = TW'(tl);
    endtask

    task automatic do_reset();
        rf_gate    = 1'b1;
        pwr_sample = '0;
        pwr_limit  = '1;
        time_limit = '0;
        ch_enable  = '1;
        arc_in     = '0;
        arc_enable = '1;
        sw_req     = '0;
        sw_enable  = '1;
        vacuum_ok  = 1'b1;
        trip_clear = 1'b0;
        rst        = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R8 reset trip_a", int'(trip_a), 0);
        chk("R9 reset trip_b", int'(trip_b), 0);
        chk("R10 reset code", int'(fault_code), 0);

        // Table walk: R1 timing, R2 equal-to-limit is not over
        for (int i = 0; i < 8; i++) begin
            do_reset();
            set_ch(int'(VEC[i].ch), int'(VEC[i].smp), int'(VEC[i].lim), int'(VEC[i].tl));
            tick(int'(VEC[i].cyc));
            chk($sformatf("R1 vector %0d", i), int'(trip_a), int'(VEC[i].exp_trip));
            if (VEC[i].exp_trip)
                chk($sformatf("R10 vector %0d code", i), int'(fault_code), 2 + int'(VEC[i].ch));
        end

        // R2: a dip to the limit restarts the count
        do_reset();
        set_ch(4, 150, 100, 3);
        tick(3);
        set_ch(4, 100, 100, 3);
        tick(1);
        set_ch(4, 150, 100, 3);
        tick(3);
        chk("R2 dip restarts count", int'(trip_a), 0);
        tick(1);
        chk("R2 trip after full run", int'(trip_a), 1);

        // R3: gate closed ignores RF
        do_reset();
        rf_gate = 1'b0;
        set_ch(6, 4095, 0, 0);
        tick(20);
        chk("R3 gate low no trip", int'(trip_a), 0);

        // R3: gate drop restarts count
        do_reset();
        set_ch(1, 900, 10, 4);
        tick(4);
        rf_gate = 1'b0;
        tick(1);
        rf_gate = 1'b1;
        tick(4);
        chk("R3 gate drop restarts count", int'(trip_a), 0);
        tick(1);
        chk("R3 trip after gated run", int'(trip_a), 1);

        // R5: masked RF channel, then enabled
        do_reset();
        ch_enable[2] = 1'b0;
        set_ch(2, 900, 10, 0);
        tick(10);
        chk("R5 masked channel", int'(trip_a), 0);
        ch_enable[2] = 1'b1;
        tick(1);
        chk("R5 channel enabled trips", int'(trip_a), 1);
        chk("R10 rf ch2 code", int'(fault_code), 4);

        // R4: arc trip, one cycle
        do_reset();
        arc_in[5] = 1'b1;
        tick(1);
        chk("R4 arc trip", int'(trip_a), 1);
        chk("R10 arc5 code", int'(fault_code), 15);

        // R5: masked arc
        do_reset();
        arc_enable[9] = 1'b0;
        arc_in[9] = 1'b1;
        tick(10);
        chk("R5 masked arc", int'(trip_a), 0);

        // R7: software request, and masked request
        do_reset();
        sw_req[1] = 1'b1;
        tick(1);
        chk("R7 sw trip", int'(trip_a), 1);
        chk("R10 sw1 code", int'(fault_code), 25);
        do_reset();
        sw_enable[0] = 1'b0;
        sw_req[0] = 1'b1;
        tick(10);
        chk("R5 masked sw", int'(trip_a), 0);

        // R6: vacuum loss with every enable off and gate low
        do_reset();
        ch_enable = '0;
        arc_enable = '0;
        sw_enable = '0;
        rf_gate = 1'b0;
        vacuum_ok = 1'b0;
        tick(1);
        chk("R6 vacuum trip_a", int'(trip_a), 1);
        chk("R9 vacuum trip_b", int'(trip_b), 1);
        chk("R10 vacuum code", int'(fault_code), 1);

        // R8 / R10: latch, first-fault hold, clear rules
        do_reset();
        arc_in[3] = 1'b1;
        tick(1);
        arc_in[3] = 1'b0;
        tick(5);
        chk("R8 trip held", int'(trip_a), 1);
        arc_in[1] = 1'b1;
        tick(2);
        chk("R10 first fault kept", int'(fault_code), 13);
        trip_clear = 1'b1;
        tick(1);
        trip_clear = 1'b0;
        chk("R8 clear ignored while active", int'(trip_a), 1);
        chk("R9 trip_b held", int'(trip_b), 1);
        arc_in[1] = 1'b0;
        tick(1);
        trip_clear = 1'b1;
        tick(1);
        trip_clear = 1'b0;
        chk("R8 cleared", int'(trip_a), 0);
        chk("R9 cleared trip_b", int'(trip_b), 0);
        chk("R10 code cleared", int'(fault_code), 0);

        // R10: same-cycle priority
        do_reset();
        vacuum_ok = 1'b0;
        arc_in[0] = 1'b1;
        tick(1);
        chk("R10 vacuum over arc", int'(fault_code), 1);
        do_reset();
        set_ch(0, 50, 10, 0);
        arc_in[0] = 1'b1;
        tick(1);
        chk("R10 rf over arc", int'(fault_code), 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule